// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the management registers of external Ethernet PHYs over the two-wire MDC/MDIO bus. The host sees a small register bank on a simple write/read port. It sets a clock-select code, stores the PHY and register numbers, and then starts a transaction. A write starts when the 16-bit data word is stored. A read starts when a command bit goes from 0 to 1. The block builds a standard Clause 22 frame, shifts it out on MDIO and samples the PHY's reply. While the frame is on the wire it reports busy. When a read ends, the sampled word is left in a read-only result register.

MDC is derived from the system clock. A select code picks a pre-divider of 4, 6, 8, 10, 14, 20 or 28 for codes 1 to 7, and a fixed post-divider follows it. The selected code is latched when a frame starts, so it holds for the whole frame. The MDIO line is presented as a separate output, output enable and input; the three-state buffer sits outside the block. A soft-reset bit in the configuration register holds the frame engine and clock generator idle for as long as it is set.

Top module: `mdio_master`

Register map (word offsets on the 3-bit address):

| Offset | Name | Access | Contents |
|---|---|---|---|
| 0 | config | read/write | bits 2:0 clock-select code, bit 3 soft reset |
| 1 | command | read/write | bit 0 read request |
| 2 | target | read/write | bits 4:0 register number, bits 12:8 PHY address |
| 3 | write data | write (reads as 0) | 16-bit data; writing it launches a write frame |
| 4 | indicator | read-only | bit 0 busy |
| 5 | result | read-only | 16-bit data from the last read frame |

## Requirements
- R1: After reset, MDC is low, the output enable is low, and every register at offsets 0 to 5 reads zero.
- R2: One MDC period lasts pre-divider × POST_DIV system clocks. Codes 1 to 7 give pre-dividers of 4, 6, 8, 10, 14, 20 and 28, and code 0 behaves as code 1.
- R3: A write frame goes out MSB first on MDIO with the output enable high for all 64 bits, in this order: 32 ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then the 16 data bits.
- R4: A read frame sends 32 ones, 01, opcode 10, the PHY address and the register number. The output enable drops for the two turnaround bits and all 16 data bits. The 16 bits sampled in the data phase, MSB first, appear at offset 5 when the frame ends.
- R5: mdio_o changes only on a falling edge of MDC, and mdio_i is sampled on a rising edge of MDC.
- R6: Busy (offset 4, bit 0) is set from the launch until the last MDC falling edge of the frame. While busy is clear, MDC is low and the output enable is low.
- R7: Writing offset 3 launches a write frame. Writing 1 to offset 1 bit 0 launches a read frame only when that bit was 0 before; writing 1 while it is already 1 launches nothing.
- R8: A launch request that arrives while busy is set is ignored. The frame in flight is unchanged, no further frame follows, and the result register keeps its value.
- R9: Setting config bit 3 aborts any frame at once, so busy, MDC and the output enable all go low. Launch requests are ignored until the bit is cleared again.
- R10: The register number is taken from bits 4:0 of offset 2 and the PHY address from bits 12:8.
- R11: A read with no PHY answering (the line stays pulled high) leaves 16'hFFFF at offset 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Register write offset |
| bus_wdata | input | 16 | Register write data |
| bus_raddr | input | 3 | Register read offset |
| bus_rdata | output | 16 | Registered read data, valid one clock after bus_raddr |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | Drive enable for MDIO; low means released |
| mdio_i | input | 1 | Resolved level of the MDIO line |

## Verification
The bench builds the block with POST_DIV set to 2 instead of the default 8. This makes a frame at code 1 take 512 clocks, and a frame at the slowest code 7 take 3584 clocks. With that setting, every clock-select code, the zero code and the full 64-bit frames of both kinds fit easily in one run. The PHY model in the bench answers reads bit by bit on the MDC falling edges and can be switched off to test the no-responder case. Aborting a frame mid-flight and sending requests during a busy frame are both checked against a scoreboard of expected wire patterns.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int ADDR_W      = 3;
  localparam int BUS_W       = 16;
  localparam int DATA_W      = 16;
  localparam int PHY_W       = 5;
  localparam int REGN_W      = 5;
  localparam int SEL_W       = 3;
  localparam int ADR_PHY_LSB = 8;
  localparam int CFG_SRST    = 3;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ADR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_WDAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_IND  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RDAT = 3'd5;

  typedef struct packed {
    logic              rd;
    logic [SEL_W-1:0]  sel;
    logic [PHY_W-1:0]  phy;
    logic [REGN_W-1:0] regn;
    logic [DATA_W-1:0] data;
  } mdio_req_t;

  // Pre-divider for a clock-select code; code 0 falls back to the code-1 ratio.
  function automatic logic [4:0] pre_div(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd2:    pre_div = 5'd6;
      3'd3:    pre_div = 5'd8;
      3'd4:    pre_div = 5'd10;
      3'd5:    pre_div = 5'd14;
      3'd6:    pre_div = 5'd20;
      3'd7:    pre_div = 5'd28;
      default: pre_div = 5'd4;
    endcase
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
#(
  parameter int POST_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);

  localparam int MAX_HALF = 14 * POST_DIV;
  localparam int CW       = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_m1;
  logic          mdc_q;
  logic          tick;

  // Half an MDC period in system clocks: (pre_div / 2) * POST_DIV.
  always_comb begin
    half_m1 = CW'((32'(pre_div(sel)) >> 1) * POST_DIV - 1);
    tick    = run && (cnt_q == half_m1);
    rise    = tick && !mdc_q;
    fall    = tick && mdc_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc = mdc_q;

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_req_t         req,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic [SEL_W-1:0]  sel_q,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_value
);

  localparam int HDR = PRE_LEN + 4 + PHY_W + REGN_W;  // first turnaround bit
  localparam int DAT = HDR + 2;                       // first data bit
  localparam int FW  = DAT + DATA_W;                  // whole frame
  localparam int BW  = $clog2(FW);

  logic [FW-1:0]     sh_q;
  logic [FW-1:0]     frame;
  logic [BW-1:0]     idx_q;
  logic [DATA_W-1:0] rx_q;
  logic              busy_q, oe_q, rd_q, last;

  always_comb begin
    frame = {{PRE_LEN{1'b1}}, 2'b01,
             req.rd ? 2'b10 : 2'b01,
             req.phy, req.regn,
             req.rd ? 2'b11 : 2'b10,
             req.rd ? {DATA_W{1'b1}} : req.data};
    last  = (idx_q == BW'(FW - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      rx_q   <= '0;
      sel_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        oe_q   <= 1'b1;
        rd_q   <= req.rd;
        sh_q   <= frame;
        idx_q  <= '0;
        sel_q  <= req.sel;
      end
    end else begin
      if (rise && rd_q && idx_q >= BW'(DAT))
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (last) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= sh_q << 1;
          if (rd_q && idx_q == BW'(HDR - 1))
            oe_q <= 1'b0;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign mdio_o   = sh_q[FW-1];
  assign mdio_oe  = oe_q;
  assign rd_done  = busy_q && fall && last && rd_q;
  assign rd_value = rx_q;

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_value,
  output logic              soft_rst,
  output logic              start,
  output mdio_req_t         req
);

  logic [SEL_W-1:0]  sel_q;
  logic              srst_q, cmd_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REGN_W-1:0] regn_q;
  logic [DATA_W-1:0] rdat_q;
  logic              start_wr, start_rd;

  always_comb begin
    start_wr = bus_we && bus_waddr == A_WDAT && !busy && !srst_q;
    start_rd = bus_we && bus_waddr == A_CMD && bus_wdata[0] && !cmd_q
               && !busy && !srst_q;
    start    = start_wr || start_rd;
    req      = '{rd: start_rd, sel: sel_q, phy: phy_q, regn: regn_q,
                 data: bus_wdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      srst_q <= 1'b0;
      cmd_q  <= 1'b0;
      phy_q  <= '0;
      regn_q <= '0;
      rdat_q <= '0;
    end else begin
      if (bus_we) begin
        case (bus_waddr)
          A_CFG: begin
            sel_q  <= bus_wdata[SEL_W-1:0];
            srst_q <= bus_wdata[CFG_SRST];
          end
          A_CMD: cmd_q <= bus_wdata[0];
          A_ADR: begin
            regn_q <= bus_wdata[REGN_W-1:0];
            phy_q  <= bus_wdata[ADR_PHY_LSB +: PHY_W];
          end
          default: ;
        endcase
      end
      if (rd_done)
        rdat_q <= rd_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_raddr)
        A_CFG:   bus_rdata <= BUS_W'({srst_q, sel_q});
        A_CMD:   bus_rdata <= BUS_W'(cmd_q);
        A_ADR:   bus_rdata <= BUS_W'({phy_q, 3'b000, regn_q});
        A_IND:   bus_rdata <= BUS_W'(busy);
        A_RDAT:  bus_rdata <= rdat_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign soft_rst = srst_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int POST_DIV = 8,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic [2:0]  bus_waddr,
  input  logic [15:0] bus_wdata,
  input  logic [2:0]  bus_raddr,
  output logic [15:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic              soft_rst, eng_rst, start, eng_busy, rd_done;
  logic              mdc_rise, mdc_fall;
  logic [SEL_W-1:0]  run_sel;
  logic [DATA_W-1:0] rd_value;
  mdio_req_t         req;

  assign eng_rst = rst || soft_rst;

  mdio_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_waddr (bus_waddr),
    .bus_wdata (bus_wdata),
    .bus_raddr (bus_raddr),
    .bus_rdata (bus_rdata),
    .busy      (eng_busy),
    .rd_done   (rd_done),
    .rd_value  (rd_value),
    .soft_rst  (soft_rst),
    .start     (start),
    .req       (req)
  );

  mdio_clkgen #(.POST_DIV(POST_DIV)) u_clkgen (
    .clk  (clk),
    .rst  (eng_rst),
    .run  (eng_busy),
    .sel  (run_sel),
    .mdc  (mdc),
    .rise (mdc_rise),
    .fall (mdc_fall)
  );

  mdio_engine #(.PRE_LEN(PRE_LEN)) u_engine (
    .clk      (clk),
    .rst      (eng_rst),
    .start    (start),
    .req      (req),
    .rise     (mdc_rise),
    .fall     (mdc_fall),
    .mdio_i   (mdio_i),
    .busy     (eng_busy),
    .sel_q    (run_sel),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (rd_done),
    .rd_value (rd_value)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] status
);

  // R6
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  // R5
  out_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && mdio_o != $past(mdio_o)) |-> $fell(mdc));

  // R6
  oe_with_launch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> $rose(busy));

  // R4
  result_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    (status != $past(status)) |-> $fell(busy));

  // R2
  mdc_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $past(busy));

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (eng_busy),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .status  (u_regs.rdat_q)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;

  localparam int CLK_PERIOD = 10;
  localparam int POST_DIV   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_waddr = '0;
  logic [15:0] bus_wdata = '0;
  logic [2:0]  bus_raddr = '0;
  logic [15:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;
  logic        phy_val = 1'b1;

  assign mdio_i = mdio_oe ? mdio_o : phy_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.POST_DIV(POST_DIV)) i_mdio_master (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int div_of(input int sel);
    int t[8] = '{4, 4, 6, 8, 10, 14, 20, 28};
    return t[sel] * POST_DIV;
  endfunction

  // Scoreboard
  logic [63:0] exp_bits_q[$];
  logic [63:0] exp_oe_q[$];
  int          exp_per_q[$];
  int          frames_done = 0;

  // PHY model
  bit          phy_present = 1'b1;
  logic [15:0] phy_data = '0;

  // Monitor
  int          cyc = 0;
  int          rcnt = 0;
  int          t0 = 0;
  int          per = 0;
  int          r5_bad = 0;
  logic        prev_mdc = 1'b0;
  logic        prev_o = 1'b0;
  logic [63:0] cap_bits = '0;
  logic [63:0] cap_oe = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst && mdc && mdio_o != prev_o) r5_bad++;
    if (mdc && !prev_mdc) begin
      cap_bits[63-rcnt] = mdio_i;
      cap_oe[63-rcnt]   = mdio_oe;
      if (rcnt == 0) t0 = cyc;
      if (rcnt == 1) per = cyc - t0;
      if (rcnt == 63) begin
        frames_done++;
        if (exp_bits_q.size() == 0) begin
          check(0, "R8 unexpected frame", cap_bits, 64'h0);
        end else begin
          logic [63:0] eb, eo;
          int ep;
          eb = exp_bits_q.pop_front();
          eo = exp_oe_q.pop_front();
          ep = exp_per_q.pop_front();
          // R3 write frame, R4 read frame, R10 address fields
          check(cap_bits == eb, eo[0] ? "R3 R10 wire bits" : "R4 R10 wire bits",
                cap_bits, eb);
          check(cap_oe == eo, eo[0] ? "R3 oe pattern" : "R4 oe pattern",
                cap_oe, eo);
          check(per == ep, "R2 MDC period", 64'(per), 64'(ep));
          check(r5_bad == 0, "R5 mdio_o moved while MDC high", 64'(r5_bad), 64'h0);
        end
        rcnt = 0;
      end else begin
        rcnt++;
      end
    end
    if (!mdc && prev_mdc) begin
      phy_val = 1'b1;
      if (phy_present && rcnt > 35 && cap_bits[63-34] && !cap_bits[63-35]) begin
        if (rcnt == 47) phy_val = 1'b0;
        else if (rcnt >= 48) phy_val = phy_data[63-rcnt];
      end
    end
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_raddr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] d;
    bus_read(3'd4, d);
    check(d[0] == 1'b1, {tag, " R6 busy after launch"}, 64'(d), 64'h1);
    while (d[0]) bus_read(3'd4, d);
    check(exp_bits_q.size() == 0, {tag, " R6 busy held until frame end"},
          64'(exp_bits_q.size()), 64'h0);
    check(!mdc && !mdio_oe, {tag, " R6 idle lines"}, {mdc, mdio_oe}, 64'h0);
  endtask

  function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  function automatic logic [63:0] rd_frame(input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d, input bit present);
    return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r,
            present ? 2'b10 : 2'b11, present ? d : 16'hFFFF};
  endfunction

  task automatic do_write(input int sel, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d);
    exp_bits_q.push_back(wr_frame(p, r, d));
    exp_oe_q.push_back('1);
    exp_per_q.push_back(div_of(sel));
    bus_write(3'd0, 16'(sel));
    bus_write(3'd2, {3'b000, p, 3'b000, r});
    bus_write(3'd3, d);   // R7 launch on data write
    wait_idle("write");
  endtask

  task automatic do_read(input int sel, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input bit present);
    logic [15:0] got;
    phy_present = present;
    phy_data    = d;
    exp_bits_q.push_back(rd_frame(p, r, d, present));
    exp_oe_q.push_back({{46{1'b1}}, {18{1'b0}}});
    exp_per_q.push_back(div_of(sel));
    bus_write(3'd0, 16'(sel));
    bus_write(3'd2, {3'b000, p, 3'b000, r});
    bus_write(3'd1, 16'h0001);   // R7 launch on rising command bit
    wait_idle("read");
    bus_read(3'd5, got);
    if (present) check(got == d, "R4 result register", 64'(got), 64'(d));
    else         check(got == 16'hFFFF, "R11 no responder", 64'(got), 64'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int nf;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(!mdc && !mdio_oe, "R1 lines after reset", {mdc, mdio_oe}, 64'h0);
    for (int a = 0; a < 6; a++) begin
      bus_read(3'(a), d);
      check(d == 16'h0, "R1 register clear", 64'(d), 64'h0);
    end
    bus_write(3'd2, 16'h1F0A);
    bus_read(3'd2, d);
    check(d == 16'h1F0A, "R10 target field placement", 64'(d), 64'h1F0A);

    // R3 R10 R2 writes at several codes, code 0 like code 1
    do_write(1, 5'h11, 5'h0A, 16'hA5C3);
    do_write(0, 5'h1F, 5'h00, 16'h0001);
    do_write(4, 5'h00, 5'h1F, 16'h8000);

    // R4 R11 reads
    do_read(3, 5'h03, 5'h1F, 16'h5A0F, 1'b1);
    bus_write(3'd1, 16'h0000);
    do_read(7, 5'h00, 5'h01, 16'h1234, 1'b0);
    // R7: command bit already 1, writing 1 again launches nothing
    nf = frames_done;
    bus_write(3'd1, 16'h0001);
    repeat (40) @(negedge clk);
    bus_read(3'd4, d);
    check(d[0] == 1'b0 && mdc == 1'b0, "R7 no relaunch on steady bit", 64'(d), 64'h0);
    bus_write(3'd1, 16'h0000);
    phy_present = 1'b1;

    // R8 requests while busy are ignored
    exp_bits_q.push_back(wr_frame(5'h05, 5'h06, 16'h1234));
    exp_oe_q.push_back('1);
    exp_per_q.push_back(div_of(1));
    bus_write(3'd0, 16'h0001);
    bus_write(3'd2, 16'h0506);
    bus_write(3'd3, 16'h1234);
    repeat (20) @(negedge clk);
    bus_write(3'd3, 16'hBEEF);
    bus_write(3'd1, 16'h0001);
    wait_idle("R8");
    nf = frames_done;
    repeat (600) @(negedge clk);
    check(frames_done == nf, "R8 no extra frame", 64'(frames_done), 64'(nf));
    bus_read(3'd5, d);
    check(d == 16'hFFFF, "R8 result kept", 64'(d), 64'hFFFF);
    bus_write(3'd1, 16'h0000);

    // R9 soft reset aborts and blocks launches
    bus_write(3'd3, 16'h0F0F);
    repeat (100) @(negedge clk);
    bus_write(3'd0, 16'h0009);
    bus_read(3'd4, d);
    check(d[0] == 1'b0 && !mdc && !mdio_oe, "R9 abort clears busy and lines",
          {d[0], mdc, mdio_oe}, 64'h0);
    bus_write(3'd3, 16'h7777);
    repeat (50) @(negedge clk);
    bus_read(3'd4, d);
    check(d[0] == 1'b0 && !mdc, "R9 launch ignored during soft reset",
          {d[0], mdc}, 64'h0);
    rcnt = 0;
    bus_write(3'd0, 16'h0001);
    do_write(1, 5'h1A, 5'h15, 16'h3C69);

    check(exp_bits_q.size() == 0, "R6 scoreboard drained", 64'(exp_bits_q.size()), 64'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule